// File: doc/BRIEF.md
# Row Pointer and Pixel Control Sequencer

This block steps the row addresses of an image array and times the per-row pixel control strobes. Three pointers run side by side: a shutter pointer that starts each row's exposure, a pre-read pointer that prepares the group of rows to be read in the next period, and a read pointer that addresses the rows now being converted. Each pointer presents a group of six rows per row period. Three of these rows go to each of the two readout sides.

A row-period tick from the timing master advances all running pointers by one group. The scan mode selects how rows are stepped. Full mode reads every row. Pair-skip mode reads one two-row colour pair and skips the next. Pair-subsample mode steps like pair-skip but starts each alternate frame two rows further down, so consecutive frames cover complementary pairs. Inside each row period, a cycle counter drives seven timed strobes from programmable start and end counts. Two reset lines are held statically by the gain select. A CDS enable chooses between reading both the reset level and the signal level, or reading the signal level only.

The exposure lead, in row periods, sets how far the shutter pointer runs ahead of the read pointer. The read pointer raises a frame-done pulse when it returns to the top of the window.

Top module: `row_seq_ctrl`

## Requirements
- R1: After reset, the shutter pointer starts on the first tick. The pre-read pointer starts on tick number E-1 and the read pointer on tick number E, where E is `exp_per` (a value of 0 is treated as 1) and the first tick is number 0. Each pointer shows the window start row on its starting tick and advances one group on every later tick.
- R2: In full mode (`scan_mode`=0), group row i is base+i for i=0..5, and the base advances by 6 per tick.
- R3: In pair-skip mode (`scan_mode`=1), group row i is base+4*(i/2)+(i mod 2), giving offsets 0,1,4,5,8,9. The base advances by 12 per tick.
- R4: Pair-subsample mode (`scan_mode`=2) uses the offsets and stride of R3. A frame starts at the window start row and the next frame at window start + 2, alternating.
- R5: When base+stride exceeds the window end row, the next tick moves the pointer back to the frame start row. For the read pointer, `frame_done` is then high for exactly the one cycle after that tick edge.
- R6: A row's valid bit is high only when its pointer has started and the row is not beyond the window end. Before a pointer starts, all its valid bits are low.
- R7: A cycle count is 0 in the cycle after a tick edge and rises by one per clock. Timed strobe j (0=TG, 1=BIASSEL, 2=SMP_RST, 3=SMP_SIG, 4=RD_RST, 5=RD_SIG, 6=ROW_SEL) is high while start_j <= count < end_j. start_j is held in `stb_cfg[j*2*CW +: CW]` and end_j in `stb_cfg[j*2*CW+CW +: CW]`, with CW=8. Strobe j appears on `pix_ctl[j+2]`.
- R8: The two sampling strobes are never high together. When both windows overlap, SMP_SIG wins and SMP_RST is dropped.
- R9: With `cds_en` low, SMP_RST and RD_RST stay low, which skips the reset-level read.
- R10: With `gain_hi` high, `pix_ctl[1]` (SWRST) is held on and `pix_ctl[0]` (RST) off. With `gain_hi` low the reverse holds. Both lines are off during reset and follow `gain_hi` one clock later.
- R11: All timed strobes stay low until the read pointer has started.
- R12: Read row addresses change only on a tick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_tick | input | 1 | Start of a row period, one cycle wide |
| scan_mode | input | 2 | 0 full, 1 pair-skip, 2 pair-subsample |
| cds_en | input | 1 | 1 reads reset and signal levels, 0 reads signal only |
| gain_hi | input | 1 | 1 holds SWRST on, 0 holds RST on |
| win_start | input | 12 | First row of the window |
| win_end | input | 12 | Last row of the window |
| exp_per | input | 8 | Shutter lead over the read pointer, in row periods |
| stb_cfg | input | 112 | Start/end counts of the seven timed strobes |
| shut_rows | output | 72 | Six shutter row addresses, row i at [i*12 +: 12] |
| shut_vld | output | 6 | Shutter row valid bits |
| pre_rows | output | 72 | Six pre-read row addresses |
| pre_vld | output | 6 | Pre-read row valid bits |
| rd_rows | output | 72 | Six read row addresses |
| rd_vld | output | 6 | Read row valid bits |
| frame_done | output | 1 | One-cycle pulse when the read pointer wraps |
| pix_ctl | output | 9 | 0 RST, 1 SWRST, 2 TG, 3 BIASSEL, 4 SMP_RST, 5 SMP_SIG, 6 RD_RST, 7 RD_SIG, 8 ROW_SEL |

## Verification
Some properties hold on every cycle and are checked continuously: the gain lines are exclusive and follow the gain select, the two sampling strobes never overlap, reset-level strobes are absent in non-CDS mode, strobes are quiet before the read pointer starts, read addresses hold between ticks, and a frame-done pulse lands on a group at the window start. Other behaviour needs directed scenarios: the actual row sequences in each scan mode, the staggered start of the three pointers, the valid mask at the window end, the alternating start row in subsample mode, and the exact cycle on which each strobe edge falls.

// File: rtl/rowseq_pkg.sv
// Shared scan mode encoding and control-line bit positions for the row sequencer.
// Assumes the nine pixel control lines are packed as two static gain lines
// followed by the seven timed strobes.
package rowseq_pkg;
    typedef enum logic [1:0] {
        SCAN_FULL = 2'd0,
        SCAN_SKIP = 2'd1,
        SCAN_SUB  = 2'd2
    } scan_e;

    localparam int NUM_STB  = 7;
    localparam int CTL_W    = NUM_STB + 2;
    localparam int NUM_PTR  = 3;
    localparam int PTR_SHUT = 0;
    localparam int PTR_PRE  = 1;
    localparam int PTR_RD   = 2;

    localparam int STB_TG     = 0;
    localparam int STB_BIAS   = 1;
    localparam int STB_SMPRST = 2;
    localparam int STB_SMPSIG = 3;
    localparam int STB_RDRST  = 4;
    localparam int STB_RDSIG  = 5;
    localparam int STB_ROWSEL = 6;
endpackage

// File: rtl/row_stepper.sv
// One row pointer. It holds the base row of the current group and presents
// GROUP row addresses with valid bits. It starts on the first go after reset
// and advances one group on each later go. Assumes win_start <= win_end and
// that GROUP is even.
module row_stepper
    import rowseq_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int GROUP     = 6,
    parameter bit FLAG_WRAP = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic [1:0]             scan_mode,
    input  logic [ROW_W-1:0]       win_start,
    input  logic [ROW_W-1:0]       win_end,
    output logic [GROUP*ROW_W-1:0] rows,
    output logic [GROUP-1:0]       vld,
    output logic                   wrap_evt
);
    localparam int EXT_W     = ROW_W + $clog2(4 * GROUP);
    localparam int SPAN_FULL = GROUP;
    localparam int SPAN_PAIR = 2 * GROUP;

    scan_e            mode;
    logic             pair_mode;
    logic [ROW_W-1:0] base_q;
    logic             odd_q;
    logic             run_q;
    logic             wrap_q;
    logic [EXT_W-1:0] span;
    logic [EXT_W-1:0] next_ext;
    logic             at_end;
    logic             restart_odd;
    logic [ROW_W-1:0] restart_base;

    // Decode the stepping pattern and the wrap decision for the next go.
    always_comb begin
        mode         = scan_e'(scan_mode);
        pair_mode    = (mode == SCAN_SKIP) || (mode == SCAN_SUB);
        span         = pair_mode ? EXT_W'(SPAN_PAIR) : EXT_W'(SPAN_FULL);
        next_ext     = EXT_W'(base_q) + span;
        at_end       = next_ext > EXT_W'(win_end);
        restart_odd  = (mode == SCAN_SUB) && !odd_q;
        restart_base = restart_odd ? (win_start + ROW_W'(2)) : win_start;
    end

    // Pointer state: launch, advance, or wrap back to the frame start row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            odd_q  <= 1'b0;
            run_q  <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (!run_q) begin
                base_q <= win_start;
                odd_q  <= 1'b0;
                if (go) begin
                    run_q <= 1'b1;
                end
            end else if (go) begin
                if (at_end) begin
                    base_q <= restart_base;
                    odd_q  <= restart_odd;
                    wrap_q <= 1'b1;
                end else begin
                    base_q <= next_ext[ROW_W-1:0];
                end
            end
        end
    end

    assign wrap_evt = wrap_q & FLAG_WRAP;

    for (genvar i = 0; i < GROUP; i++) begin : g_row
        localparam int OFF_FULL = i;
        localparam int OFF_PAIR = (i / 2) * 4 + (i % 2);
        logic [EXT_W-1:0] row_ext;

        // Address of group row i and whether it lies inside the window.
        always_comb begin
            row_ext = EXT_W'(base_q) + (pair_mode ? EXT_W'(OFF_PAIR) : EXT_W'(OFF_FULL));
            rows[i*ROW_W +: ROW_W] = row_ext[ROW_W-1:0];
            vld[i] = run_q && (row_ext <= EXT_W'(win_end));
        end
    end
endmodule

// File: rtl/launch_sched.sv
// Staggers the start of the three pointers. The shutter starts on the first
// tick, the pre-read pointer E-1 ticks later and the read pointer E ticks
// later, where E is the exposure lead (minimum 1).
module launch_sched
    import rowseq_pkg::*;
#(
    parameter int LEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_tick,
    input  logic [LEAD_W-1:0] exp_per,
    output logic [NUM_PTR-1:0] go
);
    localparam logic [LEAD_W-1:0] LEAD_MAX = '1;

    logic [LEAD_W-1:0] lead_q;
    logic [LEAD_W-1:0] exp_eff;
    logic [LEAD_W-1:0] thr [NUM_PTR];

    // Count ticks since reset, saturating so long leads stay reachable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= '0;
        end else if (row_tick && (lead_q != LEAD_MAX)) begin
            lead_q <= lead_q + LEAD_W'(1);
        end
    end

    // Start thresholds of each pointer in ticks.
    always_comb begin
        exp_eff       = (exp_per == '0) ? LEAD_W'(1) : exp_per;
        thr[PTR_SHUT] = '0;
        thr[PTR_PRE]  = exp_eff - LEAD_W'(1);
        thr[PTR_RD]   = exp_eff;
    end

    for (genvar p = 0; p < NUM_PTR; p++) begin : g_go
        assign go[p] = row_tick && (lead_q >= thr[p]);
    end
endmodule

// File: rtl/strobe_gen.sv
// Times the seven pixel strobes inside a row period from programmable start
// and end counts. It drops the reset-level strobes when CDS is off and gives
// the signal sample priority over the reset sample.
module strobe_gen
    import rowseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       row_tick,
    input  logic                       enable,
    input  logic                       cds_en,
    input  logic [NUM_STB*2*CNT_W-1:0] stb_cfg,
    output logic [NUM_STB-1:0]         stb
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_STB-1:0] raw;

    // Cycle count within the row period, restarted by each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (row_tick) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    for (genvar j = 0; j < NUM_STB; j++) begin : g_win
        logic [CNT_W-1:0] t_on;
        logic [CNT_W-1:0] t_off;
        assign t_on   = stb_cfg[j*2*CNT_W +: CNT_W];
        assign t_off  = stb_cfg[j*2*CNT_W+CNT_W +: CNT_W];
        assign raw[j] = (cnt_q >= t_on) && (cnt_q < t_off);
    end

    // Apply the CDS gating, the sampling priority and the read-start gate.
    always_comb begin
        stb             = raw;
        stb[STB_SMPRST] = raw[STB_SMPRST] && cds_en && !raw[STB_SMPSIG];
        stb[STB_RDRST]  = raw[STB_RDRST] && cds_en;
        if (!enable) begin
            stb = '0;
        end
    end
endmodule

// File: rtl/row_seq_ctrl.sv
// Top of the row sequencer. Three pointers (shutter, pre-read, read) step
// through the window in groups of GROUP rows. A strobe generator times the
// pixel control pulses of the row being read, and the gain select holds one
// of the two reset lines on. Assumes row_tick is a single-cycle pulse and the
// configuration is held steady while pointers run.
module row_seq_ctrl
    import rowseq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int GROUP  = 6,
    parameter int CNT_W  = 8,
    parameter int LEAD_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       row_tick,
    input  logic [1:0]                 scan_mode,
    input  logic                       cds_en,
    input  logic                       gain_hi,
    input  logic [ROW_W-1:0]           win_start,
    input  logic [ROW_W-1:0]           win_end,
    input  logic [LEAD_W-1:0]          exp_per,
    input  logic [NUM_STB*2*CNT_W-1:0] stb_cfg,
    output logic [GROUP*ROW_W-1:0]     shut_rows,
    output logic [GROUP-1:0]           shut_vld,
    output logic [GROUP*ROW_W-1:0]     pre_rows,
    output logic [GROUP-1:0]           pre_vld,
    output logic [GROUP*ROW_W-1:0]     rd_rows,
    output logic [GROUP-1:0]           rd_vld,
    output logic                       frame_done,
    output logic [CTL_W-1:0]           pix_ctl
);
    logic [NUM_PTR-1:0]       go;
    logic [GROUP*ROW_W-1:0]   rows_a [NUM_PTR];
    logic [GROUP-1:0]         vld_a  [NUM_PTR];
    logic [NUM_PTR-1:0]       wrap_v;
    logic [NUM_STB-1:0]       stb;
    logic                     rst_line_q;
    logic                     swrst_line_q;

    launch_sched #(.LEAD_W(LEAD_W)) i_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_tick (row_tick),
        .exp_per  (exp_per),
        .go       (go)
    );

    for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
        row_stepper #(
            .ROW_W     (ROW_W),
            .GROUP     (GROUP),
            .FLAG_WRAP (p == PTR_RD)
        ) i_step (
            .clk       (clk),
            .rst_n     (rst_n),
            .go        (go[p]),
            .scan_mode (scan_mode),
            .win_start (win_start),
            .win_end   (win_end),
            .rows      (rows_a[p]),
            .vld       (vld_a[p]),
            .wrap_evt  (wrap_v[p])
        );
    end

    assign shut_rows  = rows_a[PTR_SHUT];
    assign shut_vld   = vld_a[PTR_SHUT];
    assign pre_rows   = rows_a[PTR_PRE];
    assign pre_vld    = vld_a[PTR_PRE];
    assign rd_rows    = rows_a[PTR_RD];
    assign rd_vld     = vld_a[PTR_RD];
    assign frame_done = |wrap_v;

    strobe_gen #(.CNT_W(CNT_W)) i_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_tick (row_tick),
        .enable   (|vld_a[PTR_RD]),
        .cds_en   (cds_en),
        .stb_cfg  (stb_cfg),
        .stb      (stb)
    );

    // Static gain lines: one reset line held on, both off during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_line_q   <= 1'b0;
            swrst_line_q <= 1'b0;
        end else begin
            rst_line_q   <= !gain_hi;
            swrst_line_q <= gain_hi;
        end
    end

    assign pix_ctl = {stb, swrst_line_q, rst_line_q};
endmodule

// File: rtl/row_seq_chk.sv
// Cycle-by-cycle properties of the row sequencer, bound to its top module.
module row_seq_chk #(
    parameter int ROW_W = 12,
    parameter int GROUP = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   row_tick,
    input logic                   cds_en,
    input logic                   gain_hi,
    input logic [ROW_W-1:0]       win_start,
    input logic [GROUP*ROW_W-1:0] rd_rows,
    input logic [GROUP-1:0]       rd_vld,
    input logic                   frame_done,
    input logic [8:0]             pix_ctl
);
    // R10
    gain_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pix_ctl[1] == $past(gain_hi)) && (pix_ctl[0] == !$past(gain_hi)));

    // R8
    sample_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_ctl[4] && pix_ctl[5]));

    // R9
    no_cds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cds_en |-> (!pix_ctl[4] && !pix_ctl[6]));

    // R11
    idle_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld == '0) |-> (pix_ctl[8:2] == '0));

    // R12
    rows_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_tick && rd_vld[0]) |=> $stable(rd_rows));

    // R5
    wrap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> rd_vld[0] &&
            ((rd_rows[ROW_W-1:0] == win_start) || (rd_rows[ROW_W-1:0] == win_start + ROW_W'(2))));
endmodule

bind row_seq_ctrl row_seq_chk #(.ROW_W(ROW_W), .GROUP(GROUP)) i_row_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_tick   (row_tick),
    .cds_en     (cds_en),
    .gain_hi    (gain_hi),
    .win_start  (win_start),
    .rd_rows    (rd_rows),
    .rd_vld     (rd_vld),
    .frame_done (frame_done),
    .pix_ctl    (pix_ctl)
);

// File: tb/test_row_seq_ctrl.sv
// Directed bench for the row sequencer: one task per scenario.
module test_row_seq_ctrl;
    localparam int CLK_P  = 10;
    localparam int ROW_W  = 12;
    localparam int GROUP  = 6;
    localparam int CNT_W  = 8;
    localparam int LEAD_W = 8;
    localparam int NSTB   = 7;
    localparam int PERIOD = 20;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      row_tick = 1'b0;
    logic [1:0]                scan_mode = 2'd0;
    logic                      cds_en = 1'b1;
    logic                      gain_hi = 1'b0;
    logic [ROW_W-1:0]          win_start = '0;
    logic [ROW_W-1:0]          win_end = '0;
    logic [LEAD_W-1:0]         exp_per = 8'd1;
    logic [NSTB*2*CNT_W-1:0]   stb_cfg = '0;
    logic [GROUP*ROW_W-1:0]    shut_rows, pre_rows, rd_rows;
    logic [GROUP-1:0]          shut_vld, pre_vld, rd_vld;
    logic                      frame_done;
    logic [8:0]                pix_ctl;

    int n_chk = 0;
    int n_err = 0;

    int st_t [NSTB] = '{2, 0, 3, 5, 1, 6, 0};
    int en_t [NSTB] = '{4, 10, 6, 8, 3, 9, 12};

    always #(CLK_P/2) clk = ~clk;

    row_seq_ctrl #(.ROW_W(ROW_W), .GROUP(GROUP), .CNT_W(CNT_W), .LEAD_W(LEAD_W)) i_row_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .row_tick(row_tick), .scan_mode(scan_mode),
        .cds_en(cds_en), .gain_hi(gain_hi), .win_start(win_start), .win_end(win_end),
        .exp_per(exp_per), .stb_cfg(stb_cfg),
        .shut_rows(shut_rows), .shut_vld(shut_vld), .pre_rows(pre_rows), .pre_vld(pre_vld),
        .rd_rows(rd_rows), .rd_vld(rd_vld), .frame_done(frame_done), .pix_ctl(pix_ctl)
    );

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rrow(input logic [GROUP*ROW_W-1:0] v, input int i);
        return int'(v[i*ROW_W +: ROW_W]);
    endfunction

    task automatic check_group(input string req, input logic [GROUP*ROW_W-1:0] v, input int offs [GROUP], input int base);
        for (int i = 0; i < GROUP; i++) begin
            check(req, rrow(v, i), base + offs[i]);
        end
    endtask

    task automatic start(input int mode, input bit cds, input bit gh, input int ws, input int we, input int ex);
        @(negedge clk);
        rst_n = 1'b0;
        scan_mode = 2'(mode);
        cds_en = cds;
        gain_hi = gh;
        win_start = ROW_W'(ws);
        win_end = ROW_W'(we);
        exp_per = LEAD_W'(ex);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Pulse one tick after the rest of the row period; returns at count 0.
    task automatic tick();
        repeat (PERIOD - 2) @(negedge clk);
        row_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        row_tick = 1'b0;
    endtask

    function automatic logic [8:0] exp_ctl(input int c, input bit cds, input bit gh);
        logic [NSTB-1:0] raw;
        logic [8:0] e;
        for (int j = 0; j < NSTB; j++) raw[j] = (c >= st_t[j]) && (c < en_t[j]);
        e[0] = !gh;
        e[1] = gh;
        e[2] = raw[0];
        e[3] = raw[1];
        e[4] = raw[2] && cds && !raw[3];
        e[5] = raw[3];
        e[6] = raw[4] && cds;
        e[7] = raw[5];
        e[8] = raw[6];
        return e;
    endfunction

    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0;
        gain_hi = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 ctl in reset", int'(pix_ctl), 0);
        check("R5 frame_done in reset", int'(frame_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 RST held in low gain", int'(pix_ctl[1:0]), 1);
        check("R6 read invalid before start", int'(rd_vld), 0);
    endtask

    task automatic test_full();
        int offs [GROUP] = '{0, 1, 2, 3, 4, 5};
        start(0, 1'b1, 1'b0, 10, 31, 2);
        tick();
        check("R1 shutter starts first", rrow(shut_rows, 0), 10);
        check("R1 shutter valid", int'(shut_vld), 63);
        check("R1 pre-read waits", int'(pre_vld), 0);
        check("R1 read waits", int'(rd_vld), 0);
        tick();
        check("R1 pre-read starts", rrow(pre_rows, 0), 10);
        check("R1 shutter advanced", rrow(shut_rows, 0), 16);
        tick();
        check_group("R2 full group", rd_rows, offs, 10);
        check("R1 pre-read one ahead", rrow(pre_rows, 0), 16);
        check("R1 shutter lead", rrow(shut_rows, 0), 22);
        repeat (8) @(negedge clk);
        check("R12 rows hold", rrow(rd_rows, 0), 10);
        tick();
        check("R2 step 6", rrow(rd_rows, 0), 16);
        tick();
        tick();
        check("R2 last group", rrow(rd_rows, 0), 28);
        check("R6 valid mask at window end", int'(rd_vld), 15);
        check("R5 no wrap yet", int'(frame_done), 0);
        tick();
        check("R5 wrap to start", rrow(rd_rows, 0), 10);
        check("R5 frame_done pulse", int'(frame_done), 1);
        @(negedge clk);
        check("R5 pulse one cycle", int'(frame_done), 0);
    endtask

    task automatic test_skip();
        int offs [GROUP] = '{0, 1, 4, 5, 8, 9};
        start(1, 1'b1, 1'b0, 0, 47, 1);
        tick();
        tick();
        check_group("R3 skip first", rd_rows, offs, 0);
        tick();
        check_group("R3 skip second", rd_rows, offs, 12);
        tick();
        tick();
        check_group("R3 skip last", rd_rows, offs, 36);
        tick();
        check("R5 skip wrap", int'(frame_done), 1);
        check_group("R3 skip restarts at start", rd_rows, offs, 0);
    endtask

    task automatic test_sub();
        int offs [GROUP] = '{0, 1, 4, 5, 8, 9};
        start(2, 1'b1, 1'b0, 0, 47, 1);
        tick();
        tick();
        check_group("R4 sub frame0", rd_rows, offs, 0);
        repeat (4) tick();
        check("R5 sub wrap", int'(frame_done), 1);
        check_group("R4 sub frame1 offset", rd_rows, offs, 2);
        tick();
        check("R4 sub frame1 stride", rrow(rd_rows, 0), 14);
        tick();
        tick();
        check_group("R4 sub frame1 last", rd_rows, offs, 38);
        check("R6 sub last valid", int'(rd_vld), 63);
        tick();
        check("R4 sub back to even", rrow(rd_rows, 0), 0);
    endtask

    task automatic test_strobes(input bit cds);
        for (int j = 0; j < NSTB; j++) begin
            stb_cfg[j*2*CNT_W +: CNT_W] = CNT_W'(st_t[j]);
            stb_cfg[j*2*CNT_W+CNT_W +: CNT_W] = CNT_W'(en_t[j]);
        end
        start(0, cds, 1'b1, 0, 1023, 1);
        tick();
        repeat (5) @(negedge clk);
        check("R11 quiet before read", int'(pix_ctl[8:2]), 0);
        check("R10 SWRST held in high gain", int'(pix_ctl[1:0]), 2);
        tick();
        for (int c = 0; c < 15; c++) begin
            if (cds) check("R7 R8 strobe timing", int'(pix_ctl), int'(exp_ctl(c, cds, 1'b1)));
            else     check("R9 non-CDS timing", int'(pix_ctl), int'(exp_ctl(c, cds, 1'b1)));
            @(negedge clk);
        end
        stb_cfg = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        test_reset();
        test_full();
        test_skip();
        test_sub();
        test_strobes(1'b1);
        test_strobes(1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule